// File: doc/BRIEF.md
# Address-Event Bus Sender Interface

This block sits between an on-chip event source and a shared, multi-sender address-event bus. The source offers one 16-bit event address at a time with a valid/ready handshake. The block keeps that address in a one-entry holding register and lowers its own private active-low request line. It then waits for its own private acknowledge. While it is acknowledged, it drives the address onto the shared data lines, releases the request at the same moment, and frees the holding register once the acknowledge returns high.

The acknowledge, read strobe and timeout lines come from an asynchronous arbiter. Each passes through a two-flop synchroniser before any logic uses it. Data drive is given as a value plus an output-enable, which the pad ring turns into tri-state pins.

Optionally, the block can stretch its own bus cycle with the shared open-drain wait line. On a falling read strobe during its drive phase, it pulls wait low for a run-time programmed number of clock cycles. It lets go early on a falling timeout edge. A programmed count of zero turns stretching off.

Top module: `aeb_sender`

## Requirements
- R1: While `rst` is high and in the cycle after it falls with no other stimulus: `bus_req_n`=1, `bus_data_oe`=0, `bus_data_o`=0, `wait_pd`=0 and `evt_ready`=1.
- R2: An event is accepted on a clock edge where `evt_valid` and `evt_ready` are both 1. `evt_ready` is 0 after that edge, and `bus_req_n` goes to 0 one edge later, provided the synchronised acknowledge is high.
- R3: While `evt_ready` is 0, `evt_valid` and `evt_addr` are ignored. The address driven is the one captured at acceptance, and the ignored event is never sent.
- R4: While requesting, the third clock edge after `bus_ack_n` falls sets `bus_data_oe`=1 with `bus_data_o` equal to the held address, and in the same cycle `bus_req_n` returns to 1.
- R5: While driving, the third clock edge after `bus_ack_n` rises clears `bus_data_oe` and sets `bus_data_o` to 0 and `evt_ready` to 1.
- R6: `bus_req_n` is never lowered while the synchronised acknowledge is low. A new event waits until `bus_ack_n` has been seen high, with request falling three edges after that rise.
- R7: `bus_data_oe` is 1 only in the drive phase. An acknowledge that arrives with no request pending leaves `bus_data_oe` at 0.
- R8: During the drive phase, with `stretch_cycles`=N>0, the third edge after a falling `bus_strobe_n` sets `wait_pd`=1 (pull wait low), and it stays 1 for exactly N cycles.
- R9: While `wait_pd` is 1, the third edge after a falling `bus_timeout_n` clears it, and it stays 0.
- R10: With `stretch_cycles`=0, a falling strobe during the drive phase leaves `wait_pd` at 0.
- R11: A falling strobe outside the drive phase leaves `wait_pd` at 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Local clock |
| rst | input | 1 | Synchronous active-high reset |
| evt_valid | input | 1 | Event source offers an address |
| evt_addr | input | 16 | Event address from the source |
| evt_ready | output | 1 | Holding register free; low while an event is in flight |
| stretch_cycles | input | 8 | Wait-stretch length in cycles; 0 disables stretching |
| bus_ack_n | input | 1 | Private acknowledge, active low, asynchronous |
| bus_strobe_n | input | 1 | Shared read strobe, active low, asynchronous |
| bus_timeout_n | input | 1 | Shared timeout, active low, asynchronous |
| bus_req_n | output | 1 | Private request, active low |
| bus_data_o | output | 16 | Address value for the shared data lines |
| bus_data_oe | output | 1 | Drive enable for the data lines (0 = high impedance) |
| wait_pd | output | 1 | Open-drain pull-down for the shared wait line (1 = pull low, 0 = release) |

## Verification
Every bus-side input crosses two synchroniser flops. A change on acknowledge therefore shows at `bus_data_oe`, `bus_req_n` and `evt_ready` on the third clock edge after it. A change on strobe or timeout shows at `wait_pd` on the third edge too. The source handshake is local: `evt_ready` drops on the accepting edge, and request falls one edge later.

The bench drives all inputs on the falling clock edge and samples there as well. For each result it checks the cycle just before the expected edge, to confirm no early change, and then the cycle just after it. The wait length is checked on both its last asserted cycle and its first released cycle.

// File: rtl/aeb_pkg.sv
package aeb_pkg;

    localparam int unsigned AEB_ADDR_W    = 16;
    localparam int unsigned AEB_STRETCH_W = 8;
    localparam int unsigned AEB_SYNC_N    = 2;

    // Bit 0 marks the requesting state, bit 1 the driving state, so the
    // request and drive-enable outputs come straight off state flops.
    typedef enum logic [1:0] {
        TX_IDLE  = 2'b00,
        TX_REQ   = 2'b01,
        TX_DRIVE = 2'b10
    } tx_state_e;

    // Synchronised view of the asynchronous bus inputs (all active low).
    typedef struct packed {
        logic ack_n;
        logic strobe_n;
        logic timeout_n;
    } bus_in_t;

    localparam int unsigned BUS_IN_W = $bits(bus_in_t);

    function automatic logic fell(input logic prev, input logic now);
        return prev & ~now;
    endfunction

endpackage

// File: rtl/aeb_sync.sv
module aeb_sync #(
    parameter int unsigned        W      = 1,
    parameter int unsigned        STAGES = 2,
    parameter logic [W-1:0]       INIT   = '1
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [W-1:0] async_i,
    output logic [W-1:0] sync_o
);

    logic [W-1:0] chain [STAGES];

    for (genvar s = 0; s < STAGES; s++) begin : g_stage
        if (s == 0) begin : g_first
            always_ff @(posedge clk) begin
                if (rst) chain[s] <= INIT;
                else     chain[s] <= async_i;
            end
        end else begin : g_next
            always_ff @(posedge clk) begin
                if (rst) chain[s] <= INIT;
                else     chain[s] <= chain[s-1];
            end
        end
    end

    assign sync_o = chain[STAGES-1];

endmodule

// File: rtl/aeb_hold.sv
module aeb_hold #(
    parameter int unsigned W = 16
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         in_valid,
    input  logic [W-1:0] in_addr,
    output logic         in_ready,
    input  logic         release_i,
    output logic [W-1:0] addr_o,
    output logic         full_o
);

    logic         full_q;
    logic [W-1:0] addr_q;

    assign in_ready = ~full_q;
    assign full_o   = full_q;
    assign addr_o   = addr_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            full_q <= 1'b0;
            addr_q <= '0;
        end else if (!full_q) begin
            if (in_valid) begin
                full_q <= 1'b1;
                addr_q <= in_addr;
            end
        end else if (release_i) begin
            full_q <= 1'b0;
        end
    end

endmodule

// File: rtl/aeb_tx_fsm.sv
module aeb_tx_fsm
    import aeb_pkg::*;
(
    input  logic clk,
    input  logic rst,
    input  logic pending,
    input  logic ack_n_s,
    output logic req_n,
    output logic drive,
    output logic done
);

    tx_state_e state_q, state_d;

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            TX_IDLE:  if (pending && ack_n_s) state_d = TX_REQ;
            TX_REQ:   if (!ack_n_s)           state_d = TX_DRIVE;
            TX_DRIVE: if (ack_n_s)            state_d = TX_IDLE;
            default:                          state_d = TX_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) state_q <= TX_IDLE;
        else     state_q <= state_d;
    end

    assign req_n = ~state_q[0];
    assign drive = state_q[1];
    assign done  = (state_q == TX_DRIVE) && ack_n_s;

endmodule

// File: rtl/aeb_wait_gen.sv
module aeb_wait_gen #(
    parameter int unsigned CNT_W = 8
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             strobe_fall,
    input  logic             timeout_fall,
    input  logic             drive,
    input  logic [CNT_W-1:0] stretch,
    output logic             wait_pd
);

    localparam logic [CNT_W-1:0] ONE = CNT_W'(1);

    logic             pd_q;
    logic [CNT_W-1:0] cnt_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            pd_q  <= 1'b0;
            cnt_q <= '0;
        end else if (!pd_q) begin
            if (strobe_fall && drive && (stretch != '0)) begin
                pd_q  <= 1'b1;
                cnt_q <= stretch;
            end
        end else if (timeout_fall || (cnt_q == ONE)) begin
            pd_q  <= 1'b0;
            cnt_q <= '0;
        end else begin
            cnt_q <= cnt_q - ONE;
        end
    end

    assign wait_pd = pd_q;

endmodule

// File: rtl/aeb_sender.sv
module aeb_sender
    import aeb_pkg::*;
#(
    parameter int unsigned ADDR_W    = AEB_ADDR_W,
    parameter int unsigned STRETCH_W = AEB_STRETCH_W,
    parameter int unsigned SYNC_N    = AEB_SYNC_N
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 evt_valid,
    input  logic [ADDR_W-1:0]    evt_addr,
    output logic                 evt_ready,
    input  logic [STRETCH_W-1:0] stretch_cycles,
    input  logic                 bus_ack_n,
    input  logic                 bus_strobe_n,
    input  logic                 bus_timeout_n,
    output logic                 bus_req_n,
    output logic [ADDR_W-1:0]    bus_data_o,
    output logic                 bus_data_oe,
    output logic                 wait_pd
);

    bus_in_t           pins, synced, synced_q;
    logic              ack_n_s;
    logic              strobe_fall, timeout_fall;
    logic              pending, drive, done;
    logic [ADDR_W-1:0] held_addr;

    assign pins = '{ack_n: bus_ack_n, strobe_n: bus_strobe_n, timeout_n: bus_timeout_n};

    aeb_sync #(
        .W      (BUS_IN_W),
        .STAGES (SYNC_N),
        .INIT   ({BUS_IN_W{1'b1}})
    ) u_sync (
        .clk     (clk),
        .rst     (rst),
        .async_i (pins),
        .sync_o  (synced)
    );

    always_ff @(posedge clk) begin
        if (rst) synced_q <= '1;
        else     synced_q <= synced;
    end

    assign ack_n_s      = synced.ack_n;
    assign strobe_fall  = fell(synced_q.strobe_n, synced.strobe_n);
    assign timeout_fall = fell(synced_q.timeout_n, synced.timeout_n);

    aeb_hold #(.W(ADDR_W)) u_hold (
        .clk       (clk),
        .rst       (rst),
        .in_valid  (evt_valid),
        .in_addr   (evt_addr),
        .in_ready  (evt_ready),
        .release_i (done),
        .addr_o    (held_addr),
        .full_o    (pending)
    );

    aeb_tx_fsm u_fsm (
        .clk     (clk),
        .rst     (rst),
        .pending (pending),
        .ack_n_s (ack_n_s),
        .req_n   (bus_req_n),
        .drive   (drive),
        .done    (done)
    );

    aeb_wait_gen #(.CNT_W(STRETCH_W)) u_wait (
        .clk          (clk),
        .rst          (rst),
        .strobe_fall  (strobe_fall),
        .timeout_fall (timeout_fall),
        .drive        (drive),
        .stretch      (stretch_cycles),
        .wait_pd      (wait_pd)
    );

    assign bus_data_oe = drive;
    assign bus_data_o  = drive ? held_addr : '0;

endmodule

// File: rtl/aeb_sender_chk.sv
module aeb_sender_chk #(
    parameter int unsigned ADDR_W    = 16,
    parameter int unsigned STRETCH_W = 8
) (
    input logic                 clk,
    input logic                 rst,
    input logic                 evt_ready,
    input logic                 bus_req_n,
    input logic                 bus_data_oe,
    input logic [ADDR_W-1:0]    bus_data_o,
    input logic                 wait_pd,
    input logic [STRETCH_W-1:0] stretch_cycles,
    input logic                 ack_n_s,
    input logic                 timeout_fall
);

    // R2: a free holding register means no request and no drive
    assert_free_is_idle_R2: assert property (@(posedge clk) disable iff (rst)
        evt_ready |-> (bus_req_n && !bus_data_oe));

    // R3: the driven address does not change during one drive phase
    assert_data_stable_R3: assert property (@(posedge clk) disable iff (rst)
        (bus_data_oe && $past(bus_data_oe)) |-> $stable(bus_data_o));

    // R4: drive starts only after acknowledge was seen low
    assert_drive_on_ack_R4: assert property (@(posedge clk) disable iff (rst)
        $rose(bus_data_oe) |-> (!$past(ack_n_s) && bus_req_n));

    // R5: drive stops only after acknowledge was seen high
    assert_drive_off_ack_R5: assert property (@(posedge clk) disable iff (rst)
        $fell(bus_data_oe) |-> $past(ack_n_s));

    // R6: request is lowered only while acknowledge is high
    assert_req_after_ack_high_R6: assert property (@(posedge clk) disable iff (rst)
        $fell(bus_req_n) |-> $past(ack_n_s));

    // R8: wait is taken only in the drive phase with a nonzero count
    assert_wait_in_drive_R8: assert property (@(posedge clk) disable iff (rst)
        $rose(wait_pd) |-> ($past(bus_data_oe) && ($past(stretch_cycles) != '0)));

    // R9: a timeout edge releases wait
    assert_timeout_release_R9: assert property (@(posedge clk) disable iff (rst)
        (wait_pd && timeout_fall) |=> !wait_pd);

endmodule

bind aeb_sender aeb_sender_chk #(.ADDR_W(ADDR_W), .STRETCH_W(STRETCH_W)) u_chk (
    .clk            (clk),
    .rst            (rst),
    .evt_ready      (evt_ready),
    .bus_req_n      (bus_req_n),
    .bus_data_oe    (bus_data_oe),
    .bus_data_o     (bus_data_o),
    .wait_pd        (wait_pd),
    .stretch_cycles (stretch_cycles),
    .ack_n_s        (ack_n_s),
    .timeout_fall   (timeout_fall)
);

// File: tb/aeb_sender_bench.sv
`timescale 1ns/1ps
module aeb_sender_bench;

    logic        clk = 1'b0;
    logic        rst;
    logic        evt_valid;
    logic [15:0] evt_addr;
    logic        evt_ready;
    logic [7:0]  stretch_cycles;
    logic        bus_ack_n, bus_strobe_n, bus_timeout_n;
    logic        bus_req_n;
    logic [15:0] bus_data_o;
    logic        bus_data_oe;
    logic        wait_pd;

    int checks = 0;
    int errors = 0;
    bit done_flag = 0;

    always #10 clk = ~clk;

    aeb_sender u_aeb_sender (
        .clk            (clk),
        .rst            (rst),
        .evt_valid      (evt_valid),
        .evt_addr       (evt_addr),
        .evt_ready      (evt_ready),
        .stretch_cycles (stretch_cycles),
        .bus_ack_n      (bus_ack_n),
        .bus_strobe_n   (bus_strobe_n),
        .bus_timeout_n  (bus_timeout_n),
        .bus_req_n      (bus_req_n),
        .bus_data_o     (bus_data_o),
        .bus_data_oe    (bus_data_oe),
        .wait_pd        (wait_pd)
    );

    task automatic check(input string req, input string what, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s %s: actual 0x%0h expected 0x%0h", req, what, act, exp);
        end
    endtask

    task automatic step(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic finish_run();
        if (!done_flag) begin
            done_flag = 1;
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    endtask

    // offer one event and wait until request is low
    task automatic offer(input logic [15:0] a);
        evt_valid = 1'b1; evt_addr = a;
        step(1);
        evt_valid = 1'b0;
        check("R2", "ready after accept", evt_ready, 0);
        check("R2", "req one edge after accept", bus_req_n, 1);
        step(1);
        check("R2", "req low", bus_req_n, 0);
    endtask

    task automatic grant(input logic [15:0] a);
        bus_ack_n = 1'b0;
        step(2);
        check("R4", "oe before 3rd edge", bus_data_oe, 0);
        step(1);
        check("R4", "oe on ack", bus_data_oe, 1);
        check("R4", "data on ack", bus_data_o, a);
        check("R4", "req released", bus_req_n, 1);
    endtask

    task automatic retire();
        bus_ack_n = 1'b1;
        step(2);
        check("R5", "oe before 3rd edge", bus_data_oe, 1);
        step(1);
        check("R5", "oe after ack high", bus_data_oe, 0);
        check("R5", "data zero", bus_data_o, 0);
        check("R5", "ready back", evt_ready, 1);
    endtask

    task automatic t_reset();
        rst = 1'b1; evt_valid = 1'b0; evt_addr = '0; stretch_cycles = '0;
        bus_ack_n = 1'b1; bus_strobe_n = 1'b1; bus_timeout_n = 1'b1;
        step(3);
        check("R1", "req in reset", bus_req_n, 1);
        check("R1", "oe in reset", bus_data_oe, 0);
        rst = 1'b0;
        step(1);
        check("R1", "req", bus_req_n, 1);
        check("R1", "oe", bus_data_oe, 0);
        check("R1", "data", bus_data_o, 0);
        check("R1", "wait", wait_pd, 0);
        check("R1", "ready", evt_ready, 1);
    endtask

    task automatic t_basic();
        offer(16'hA5C3);
        step(3);
        check("R7", "no drive without ack", bus_data_oe, 0);
        grant(16'hA5C3);
        retire();
        offer(16'h0001);
        grant(16'h0001);
        retire();
        offer(16'hFFFF);
        grant(16'hFFFF);
        retire();
    endtask

    task automatic t_busy_ignore();
        offer(16'h1234);
        evt_valid = 1'b1; evt_addr = 16'hBEEF;
        step(4);
        check("R3", "still busy", evt_ready, 0);
        evt_valid = 1'b0;
        grant(16'h1234);
        check("R3", "first address kept", bus_data_o, 16'h1234);
        retire();
        step(5);
        check("R3", "ignored event not sent", bus_req_n, 1);
        check("R3", "no drive", bus_data_oe, 0);
    endtask

    task automatic t_stray_ack();
        bus_ack_n = 1'b0;
        step(5);
        check("R7", "stray ack no drive", bus_data_oe, 0);
        evt_valid = 1'b1; evt_addr = 16'h5A5A;
        step(1);
        evt_valid = 1'b0;
        step(4);
        check("R6", "no req while ack low", bus_req_n, 1);
        check("R7", "no drive before request", bus_data_oe, 0);
        bus_ack_n = 1'b1;
        step(2);
        check("R6", "req before ack seen high", bus_req_n, 1);
        step(1);
        check("R6", "req after ack high", bus_req_n, 0);
        grant(16'h5A5A);
        retire();
    endtask

    task automatic t_wait_full();
        stretch_cycles = 8'd4;
        offer(16'h00C0);
        grant(16'h00C0);
        bus_strobe_n = 1'b0;
        step(2);
        check("R8", "wait before 3rd edge", wait_pd, 0);
        step(1);
        check("R8", "wait asserted", wait_pd, 1);
        step(3);
        check("R8", "wait last cycle", wait_pd, 1);
        step(1);
        check("R8", "wait released after N", wait_pd, 0);
        bus_strobe_n = 1'b1;
        retire();
    endtask

    task automatic t_wait_timeout();
        stretch_cycles = 8'd40;
        offer(16'h0DD0);
        grant(16'h0DD0);
        bus_strobe_n = 1'b0;
        step(5);
        check("R8", "wait held", wait_pd, 1);
        bus_timeout_n = 1'b0;
        step(2);
        check("R9", "wait before 3rd edge", wait_pd, 1);
        step(1);
        check("R9", "wait released on timeout", wait_pd, 0);
        step(4);
        check("R9", "wait stays released", wait_pd, 0);
        bus_timeout_n = 1'b1; bus_strobe_n = 1'b1;
        retire();
    endtask

    task automatic t_wait_zero();
        stretch_cycles = 8'd0;
        offer(16'h7777);
        grant(16'h7777);
        bus_strobe_n = 1'b0;
        for (int i = 0; i < 6; i++) begin
            step(1);
            check("R10", "no wait with zero count", wait_pd, 0);
        end
        bus_strobe_n = 1'b1;
        retire();
    endtask

    task automatic t_strobe_idle();
        stretch_cycles = 8'd4;
        step(2);
        bus_strobe_n = 1'b0;
        for (int i = 0; i < 6; i++) begin
            step(1);
            check("R11", "no wait outside drive", wait_pd, 0);
        end
        bus_strobe_n = 1'b1;
        step(3);
    endtask

    initial begin
        t_reset();
        t_basic();
        t_busy_ignore();
        t_stray_ack();
        t_wait_full();
        t_wait_timeout();
        t_wait_zero();
        t_strobe_idle();
        finish_run();
    end

    initial begin
        repeat (20000) @(posedge clk);
        errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        finish_run();
    end

endmodule